// File: doc/BRIEF.md
# Single-Wire Bus Master with Strong Pullup

The block drives a single open-drain line as a bus master. Every bit goes out as a fixed-length time slot. The host hands over one byte at a time, and the block sends it least significant bit first. In each slot the block samples the line and shifts the sampled bit into a receive register, so every byte written returns one byte read. A read is a write of all ones: an attached device answers a one-slot by holding the line low past the sample point. All slot timing counts pulses of a one-microsecond tick-enable input, so the block runs from any system clock.

A bit-countdown register supports commands that need a strong pullup after their last bit. The host loads the register with the command length in bits minus one. The register is decremented in every slot. If it runs out on a slot that writes a zero, the block drives the line actively high as soon as that slot's low phase ends. It keeps driving high until the host gives a release request. It then goes back to open-drain and gives a one-cycle acknowledge. When the register holds all ones it is disarmed and never runs out.

Top module: `owm_master`

## Requirements
- R1: After reset the line is released (`busLow`=0, `busHigh`=0), `txReady`=1, and `rxValid` and `pullupDone` are 0.
- R2: Every slot opens with `busLow` asserted for exactly 6 ticks when the bit is 1. The bus outputs change only on a tick cycle, except when leaving the waiting or pullup states.
- R3: A slot that writes a 0 keeps `busLow` asserted for exactly 60 ticks.
- R4: Before each slot of a byte after its first, the line is released for 12 ticks if the previous bit was 0, and for 66 ticks (6 + 48 + 12) if it was 1.
- R5: For a 1 bit the line is sampled on the 12th tick after the slot starts. For a 0 bit a 0 is recorded. Bits fill `rxByte` LSB first, so with a device answering `dev`, the result is `txByte & dev`.
- R6: Each accepted byte yields exactly one `rxValid` pulse, in order. `txReady` is high only while the block waits with the line released, and it falls on the cycle after a byte is accepted.
- R7: A loaded count of N-1 runs out on the Nth slot after the load. A count of all ones never runs out.
- R8: When the count runs out on a 0 slot, `busHigh` rises on the same edge that `busLow` falls. `busHigh` then stays high until `releaseReq`.
- R9: On `releaseReq` during the pullup, `busHigh` falls and `pullupDone` pulses for one cycle on the same edge. Any bits left in the byte then continue.
- R10: When the count runs out on a 1 slot, no pullup follows and the count becomes disarmed (all ones).
- R11: `releaseReq` outside the pullup has no effect: `pullupDone` stays 0 and the line stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickUs | input | 1 | One-cycle pulse per microsecond |
| txValid | input | 1 | Byte offered for transmission |
| txByte | input | 8 | Byte to send, LSB first |
| txReady | output | 1 | Block idle and accepting a byte |
| cntLoad | input | 1 | Load the bit countdown |
| cntValue | input | CNT_W | Bits in the command minus one; all ones disarms |
| releaseReq | input | 1 | Host ends the strong pullup |
| busIn | input | 1 | Sampled level of the bus line |
| busLow | output | 1 | Pull the line low |
| busHigh | output | 1 | Drive the line actively high |
| rxValid | output | 1 | One-cycle strobe for a completed received byte |
| rxByte | output | 8 | Received byte, first slot in bit 0 |
| pullupDone | output | 1 | One-cycle acknowledge that the pullup ended |

## Verification
The assertions check the pullup handshake on every cycle. They check that the pullup starts only out of a low phase, is held until a release, and that the acknowledge matches the release exactly. They also check that a disarmed countdown stays disarmed and that the bus moves only on tick cycles. Slot lengths, recovery gaps, the sample point and the wired-AND result can only be shown by the bench's scenarios, which drive a device model. The same holds for the countdown reaching exactly the Nth slot, a count of zero causing a pullup in the middle of a byte, and a count running out on a 1 bit.

// File: rtl/owm_pkg.sv
package owm_pkg;

  // Phases of one bus slot plus the idle and pullup states.
  typedef enum logic [2:0] {
    ST_WAIT,   // released, no byte pending
    ST_REC,    // recovery, line released
    ST_LOW,    // opening low pulse of every slot
    ST_GAP,    // released, waiting for the sample point
    ST_TAIL1,  // released remainder of a one-slot
    ST_TAIL0,  // held-low remainder of a zero-slot
    ST_HOLD    // active-high strong pullup
  } slotState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadByte;    // capture host byte
    logic takeSample;  // shift sampled line level into receive register
    logic takeZero;    // shift a forced zero into receive register
    logic stepCnt;     // one slot done: step the countdown
  } dpStrobe_t;

endpackage

// File: rtl/owm_datapath.sv
module owm_datapath
  import owm_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [BYTE_W-1:0] txByte,
  input  logic              busIn,
  input  logic              cntLoad,
  input  logic [CNT_W-1:0]  cntValue,
  output logic              curBit,
  output logic              moreBits,
  output logic              cntZero,
  output logic              rxValid,
  output logic [BYTE_W-1:0] rxByte
);

  localparam int IDX_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_OFF  = '1;

  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] rxShift;
  logic [IDX_W-1:0]  bitIdx;
  logic [CNT_W-1:0]  bitCnt;
  logic              shiftNow;
  logic              newBit;

  assign shiftNow = stb.takeSample | stb.takeZero;
  assign newBit   = stb.takeSample ? busIn : 1'b0;
  assign curBit   = txShift[0];
  assign moreBits = (bitIdx != '0);
  assign cntZero  = (bitCnt == '0);
  assign rxByte   = rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      bitIdx  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (stb.loadByte) begin
        txShift <= txByte;
        bitIdx  <= '0;
      end else if (shiftNow) begin
        txShift <= {1'b0, txShift[BYTE_W-1:1]};
        rxShift <= {newBit, rxShift[BYTE_W-1:1]};
        bitIdx  <= (bitIdx == LAST_IDX) ? '0 : bitIdx + 1'b1;
        rxValid <= (bitIdx == LAST_IDX);
      end
    end
  end

  // Countdown: a load wins; all ones is parked; reaching zero disarms.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= CNT_OFF;
    end else if (cntLoad) begin
      bitCnt <= cntValue;
    end else if (stb.stepCnt && bitCnt != CNT_OFF) begin
      bitCnt <= cntZero ? CNT_OFF : bitCnt - 1'b1;
    end
  end

  assert_disarmed_stays_R7: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt == CNT_OFF && !cntLoad) |=> (bitCnt == CNT_OFF));

  assert_expiry_disarms_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepCnt && cntZero && !cntLoad) |=> (bitCnt == CNT_OFF));

  assert_single_shift_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.takeSample && stb.takeZero));

  assert_rx_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

endmodule

// File: rtl/owm_control.sv
module owm_control
  import owm_pkg::*;
#(
  parameter int LOW_US    = 6,
  parameter int SAMPLE_US = 6,
  parameter int SLOT_US   = 60,
  parameter int REC_US    = 12
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickUs,
  input  logic      txValid,
  input  logic      releaseReq,
  input  logic      curBit,
  input  logic      moreBits,
  input  logic      cntZero,
  output dpStrobe_t stb,
  output logic      txReady,
  output logic      busLow,
  output logic      busHigh,
  output logic      pullupDone
);

  localparam int TAIL1_US = SLOT_US - LOW_US - SAMPLE_US;
  localparam int TAIL0_US = SLOT_US - LOW_US;
  localparam int MAX_US   = (SLOT_US > REC_US) ? SLOT_US : REC_US;
  localparam int TMR_W    = $clog2(MAX_US + 1);

  slotState_t       state, nxt;
  logic [TMR_W-1:0] timer;
  logic             tickDone;
  logic             pullPend;

  function automatic logic [TMR_W-1:0] durOf(input slotState_t s);
    case (s)
      ST_REC:   durOf = TMR_W'(REC_US - 1);
      ST_LOW:   durOf = TMR_W'(LOW_US - 1);
      ST_GAP:   durOf = TMR_W'(SAMPLE_US - 1);
      ST_TAIL1: durOf = TMR_W'(TAIL1_US - 1);
      ST_TAIL0: durOf = TMR_W'(TAIL0_US - 1);
      default:  durOf = '0;
    endcase
  endfunction

  assign tickDone = tickUs && (timer == '0);

  always_comb begin
    nxt = state;
    stb = '0;
    case (state)
      ST_WAIT: if (txValid) begin
        nxt = ST_REC;
        stb.loadByte = 1'b1;
      end
      ST_REC: if (tickDone) nxt = ST_LOW;
      ST_LOW: if (tickDone) begin
        stb.stepCnt = 1'b1;
        if (curBit) begin
          nxt = ST_GAP;
        end else begin
          nxt = ST_TAIL0;
          stb.takeZero = 1'b1;
        end
      end
      ST_GAP: if (tickDone) begin
        stb.takeSample = 1'b1;
        nxt = ST_TAIL1;
      end
      ST_TAIL1: if (tickDone) nxt = moreBits ? ST_REC : ST_WAIT;
      ST_TAIL0: if (tickDone) begin
        if (pullPend) nxt = ST_HOLD;
        else          nxt = moreBits ? ST_REC : ST_WAIT;
      end
      ST_HOLD: if (releaseReq) nxt = moreBits ? ST_REC : ST_WAIT;
      default: nxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_WAIT;
      timer      <= '0;
      pullPend   <= 1'b0;
      pullupDone <= 1'b0;
    end else begin
      state      <= nxt;
      pullupDone <= (state == ST_HOLD) && releaseReq;
      if (nxt != state)                 timer <= durOf(nxt);
      else if (tickUs && timer != '0)   timer <= timer - 1'b1;
      if (stb.stepCnt)                  pullPend <= !curBit && cntZero;
      else if (state == ST_HOLD)        pullPend <= 1'b0;
    end
  end

  assign txReady = (state == ST_WAIT);
  assign busLow  = (state == ST_LOW) || (state == ST_TAIL0);
  assign busHigh = (state == ST_HOLD);

  assert_pullup_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busHigh) |-> $past(busLow));

  assert_hold_until_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busHigh && !releaseReq) |=> busHigh);

  assert_release_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busHigh) |-> pullupDone);

  assert_ack_needs_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    pullupDone |-> $past(busHigh));

  assert_accept_leaves_wait_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && txValid) |=> (!txReady && !busLow && !busHigh));

  assert_moves_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!tickUs && !txReady && !busHigh) |=> $stable(busLow));

endmodule

// File: rtl/owm_master.sv
module owm_master
  import owm_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int CNT_W     = 16,
  parameter int LOW_US    = 6,
  parameter int SAMPLE_US = 6,
  parameter int SLOT_US   = 60,
  parameter int REC_US    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickUs,
  input  logic              txValid,
  input  logic [BYTE_W-1:0] txByte,
  output logic              txReady,
  input  logic              cntLoad,
  input  logic [CNT_W-1:0]  cntValue,
  input  logic              releaseReq,
  input  logic              busIn,
  output logic              busLow,
  output logic              busHigh,
  output logic              rxValid,
  output logic [BYTE_W-1:0] rxByte,
  output logic              pullupDone
);

  dpStrobe_t stb;
  logic      curBit;
  logic      moreBits;
  logic      cntZero;

  owm_control #(
    .LOW_US(LOW_US), .SAMPLE_US(SAMPLE_US), .SLOT_US(SLOT_US), .REC_US(REC_US)
  ) i_control (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .txValid(txValid),
    .releaseReq(releaseReq), .curBit(curBit), .moreBits(moreBits),
    .cntZero(cntZero), .stb(stb), .txReady(txReady), .busLow(busLow),
    .busHigh(busHigh), .pullupDone(pullupDone)
  );

  owm_datapath #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .txByte(txByte), .busIn(busIn),
    .cntLoad(cntLoad), .cntValue(cntValue), .curBit(curBit),
    .moreBits(moreBits), .cntZero(cntZero), .rxValid(rxValid), .rxByte(rxByte)
  );

endmodule

// File: tb/test_owm_master.sv
`timescale 1ns/1ps
module test_owm_master;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickUs = 1'b0;
  logic        txValid = 1'b0;
  logic [7:0]  txByte = '0;
  logic        txReady;
  logic        cntLoad = 1'b0;
  logic [15:0] cntValue = '0;
  logic        releaseReq = 1'b0;
  logic        busIn;
  logic        busLow, busHigh, rxValid, pullupDone;
  logic [7:0]  rxByte;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  owm_master i_owm_master (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .txValid(txValid), .txByte(txByte),
    .txReady(txReady), .cntLoad(cntLoad), .cntValue(cntValue),
    .releaseReq(releaseReq), .busIn(busIn), .busLow(busLow), .busHigh(busHigh),
    .rxValid(rxValid), .rxByte(rxByte), .pullupDone(pullupDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Tick every 4 clocks, driven just after the edge.
  initial begin
    forever begin
      for (int i = 0; i < 3; i++) @(posedge clk);
      #1 tickUs = 1'b1;
      @(posedge clk);
      #1 tickUs = 1'b0;
    end
  end

  // Device model: answers a 0 bit by holding the line 15 ticks.
  logic [7:0] devPattern = 8'hFF;
  int  sIdx = 0;
  int  sHold = 0;
  bit  sPrevLow = 0;
  assign busIn = !(busLow || sHold != 0);

  always @(negedge clk) begin
    if (!rstN) begin
      sIdx = 0; sHold = 0; sPrevLow = 0;
    end else begin
      if (busLow && !sPrevLow) begin
        sHold = devPattern[sIdx] ? 0 : 15;
        sIdx = (sIdx + 1) % 8;
      end else if (tickUs && sHold > 0) begin
        sHold--;
      end
      sPrevLow = busLow;
    end
  end

  // Scoreboard queues filled by the driver.
  int         bitQ[$];
  logic [7:0] rxQ[$];

  // Monitor.
  bit prevLow = 0, prevHigh = 0, heldSince = 0, highSeen = 0;
  int lowLen = 0, gapLen = 0, prevBit = 0, slotCount = 0, doneCount = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (busLow && !prevLow) begin
        if (slotCount % 8 != 0 && !heldSince)
          check(gapLen == (prevBit ? 66 : 12), "R4", "recovery ticks",
                gapLen, prevBit ? 66 : 12);
        slotCount++;
        lowLen = tickUs ? 1 : 0;
      end else if (busLow && tickUs) begin
        lowLen++;
      end
      if (!busLow && prevLow) begin
        int expBit;
        expBit = (bitQ.size() > 0) ? bitQ.pop_front() : -1;
        check(lowLen == (expBit == 1 ? 6 : 60), expBit == 1 ? "R2" : "R3",
              "low ticks", lowLen, expBit == 1 ? 6 : 60);
        prevBit = expBit;
        heldSince = 0;
        gapLen = tickUs ? 1 : 0;
      end else if (!busLow && tickUs) begin
        gapLen++;
      end
      if (busHigh && !prevHigh) begin
        highSeen = 1;
        heldSince = 1;
        check(prevLow, "R8", "pullup starts as low phase ends", prevLow, 1);
      end
      if (rxValid) begin
        logic [7:0] expByte;
        expByte = (rxQ.size() > 0) ? rxQ.pop_front() : 8'hXX;
        check(rxByte === expByte, "R5", "received byte", rxByte, expByte);
      end
      if (pullupDone) doneCount++;
      prevLow = busLow;
      prevHigh = busHigh;
    end
  end

  task automatic sendByte(input logic [7:0] b, input logic [7:0] dev);
    while (!txReady) @(negedge clk);
    @(posedge clk);
    #1;
    devPattern = dev;
    txValid = 1'b1;
    txByte = b;
    for (int i = 0; i < 8; i++) bitQ.push_back(int'(b[i]));
    rxQ.push_back(b & dev);
    @(posedge clk);
    #1 txValid = 1'b0;
  endtask

  task automatic loadCount(input logic [15:0] v);
    @(posedge clk);
    #1 cntLoad = 1'b1; cntValue = v;
    @(posedge clk);
    #1 cntLoad = 1'b0;
  endtask

  task automatic drain();
    while (!(txReady && bitQ.size() == 0 && rxQ.size() == 0)) @(negedge clk);
    check(1, "R6", "queues drained", 0, 0);
  endtask

  task automatic pulseRelease();
    @(posedge clk);
    #1 releaseReq = 1'b1;
    @(posedge clk);
    #1 releaseReq = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R6", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int startSlots, d0, waitCyc;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!busLow && !busHigh, "R1", "line released", busLow | busHigh, 0);
    check(txReady, "R1", "txReady", txReady, 1);
    check(!rxValid && !pullupDone, "R1", "strobes idle", rxValid | pullupDone, 0);

    // R5/R6/R7: disarmed countdown, mixed patterns, no pullup
    sendByte(8'hA5, 8'hFF);
    @(negedge clk);
    check(!txReady, "R6", "txReady low while busy", txReady, 0);
    sendByte(8'h3C, 8'h0F);
    sendByte(8'h00, 8'hFF);
    sendByte(8'hFF, 8'h96);
    drain();
    check(!highSeen, "R7", "disarmed count gives no pullup", highSeen, 0);

    // R11: release outside pullup is ignored
    d0 = doneCount;
    pulseRelease();
    repeat (20) @(negedge clk);
    check(doneCount == d0, "R11", "no acknowledge", doneCount - d0, 0);
    check(!busHigh && !busLow && txReady, "R11", "line stays released", busHigh | busLow, 0);

    // R7/R8/R9: 16-bit command, last bit 0
    loadCount(16'd15);
    startSlots = slotCount;
    sendByte(8'h55, 8'hFF);
    sendByte(8'h44, 8'hFF);
    waitCyc = 0;
    while (!busHigh && waitCyc < 20000) begin @(negedge clk); waitCyc++; end
    check(busHigh, "R8", "pullup asserted", busHigh, 1);
    check(slotCount - startSlots == 16, "R7", "slots before pullup", slotCount - startSlots, 16);
    d0 = doneCount;
    repeat (300) @(negedge clk);
    check(busHigh && !busLow, "R8", "pullup held", busHigh, 1);
    check(doneCount == d0, "R8", "no early acknowledge", doneCount - d0, 0);
    pulseRelease();
    @(negedge clk);
    check(!busHigh, "R9", "pullup released", busHigh, 0);
    check(pullupDone, "R9", "acknowledge pulse", pullupDone, 1);
    @(negedge clk);
    check(!pullupDone, "R9", "acknowledge one cycle", pullupDone, 0);
    check(txReady && !busLow, "R9", "back to open-drain idle", txReady, 1);
    drain();

    // R10: count runs out on a 1 bit, then disarmed
    highSeen = 0;
    loadCount(16'd7);
    sendByte(8'hFF, 8'hFF);
    sendByte(8'h00, 8'hFF);
    drain();
    check(!highSeen, "R10", "no pullup after a 1 bit", highSeen, 0);

    // R7/R9: count of zero, pullup after first slot, rest continues
    loadCount(16'd0);
    startSlots = slotCount;
    sendByte(8'h02, 8'hFF);
    waitCyc = 0;
    while (!busHigh && waitCyc < 5000) begin @(negedge clk); waitCyc++; end
    check(busHigh, "R8", "mid-byte pullup", busHigh, 1);
    check(slotCount - startSlots == 1, "R7", "count zero expires first slot",
          slotCount - startSlots, 1);
    check(!txReady, "R9", "byte still in progress", txReady, 0);
    pulseRelease();
    drain();
    check(bitQ.size() == 0, "R9", "remaining bits sent", bitQ.size(), 0);

    summary();
  end

endmodule